// File: doc/BRIEF.md
# Flash Page Refresh Scheduler

This controller walks the pages of a flash array in the background so that retention drift is cleaned up before it exceeds what the ECC can correct. At each sweep it reads every page in ascending order. It takes the corrected-bit count and the uncorrectable flag from an external ECC decoder when each read completes. It then writes the page back, either by reprogramming it in place or by remapping it to a fresh physical page. The ECC decoder, the flash timing and the mapping table sit outside the block. The block only issues commands and waits for their completion.

Sweeps are started by an interval counter that counts timer ticks while the block is idle. The interval is either a fixed value or one looked up from a small table of wear bands, indexed by the program/erase count. The write-back choice is remap-only, reprogram-only, or a hybrid policy. In hybrid mode a page is relocated when its error count is high, or when it has been reprogrammed in place too often since its last relocation. A page that cannot be corrected is skipped. Its address is recorded and the sweep goes on.

The command port is valid/ready. `cmd_valid_o` stays asserted with a stable opcode and address until the cycle in which `cmd_ready_i` is high. That cycle is the hand-off. Only one command is in flight at a time. The next command is not presented until `done_i` has been seen for the previous one. A `done_i` pulse at any other time is ignored. ECC status is sampled only in the cycle of a read's `done_i`.

Top module: `pgref_sched`

## Requirements
- R1: After reset, `cmd_valid_o`, `busy_o` and `err_flag_o` are 0, `err_addr_o` is 0, and every page's in-place rewrite count is 0.
- R2: With `adapt_i`=0, a sweep starts when the number of ticks counted while idle reaches `fixed_ivl_i`. A value of 0 acts as 1. `cmd_valid_o` rises in the cycle after the tick that completes the count. The tick count restarts from 0 at every sweep start.
- R3: With `adapt_i`=1, the interval is the tick count of the highest band whose P/E threshold is at or below `pe_cycles_i`. The default bands are P/E 0 → 12, 100 → 8 and 200 → 4. A count below the first threshold uses the first band. Any count at or above the last threshold uses the last, shortest band.
- R4: A sweep issues a read (opcode 1) to each page in turn from address 0 up to the last page. It returns to idle after the last page, and the next sweep begins at address 0 again. Every write-back carries the address of the read that preceded it. `busy_o` is 1 from sweep start until that return.
- R5: After a command is handed off, no new command is presented until `done_i` is seen. A `done_i` pulse while no command is outstanding changes nothing.
- R6: While `cmd_valid_o`=1 and `cmd_ready_i`=0, `cmd_valid_o`, `cmd_op_o` and `cmd_addr_o` hold their values.
- R7: With `mode_i`=0, every write-back is a remap (opcode 3).
- R8: With `mode_i`=1, every write-back is an in-place reprogram (opcode 2).
- R9: With `mode_i`=2 or 3 (hybrid), a page is remapped when its corrected-bit count is greater than `corr_thr_i`, or when its rewrite count is at or above `reprog_limit_i`. Otherwise it is reprogrammed.
- R10: A completed reprogram raises that page's rewrite count by one, saturating at its maximum (7 by default). A completed remap clears it. Reads leave it unchanged.
- R11: A read whose `ecc_fail_i` is 1 gets no write-back. `err_addr_o` takes that page's address, `err_flag_o` becomes 1 and stays 1 until reset, and the sweep moves on to the next page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Refresh timer tick |
| adapt_i | input | 1 | 1 selects the wear-band interval, 0 selects the fixed interval |
| fixed_ivl_i | input | 16 | Fixed interval in ticks |
| pe_cycles_i | input | 16 | Endured program/erase count |
| mode_i | input | 2 | 0 remap only, 1 reprogram only, 2/3 hybrid |
| corr_thr_i | input | 6 | Hybrid corrected-bit threshold |
| reprog_limit_i | input | 3 | Hybrid in-place rewrite limit |
| cmd_valid_o | output | 1 | Command presented |
| cmd_ready_i | input | 1 | Flash side accepts the command |
| cmd_op_o | output | 2 | 1 read, 2 reprogram in place, 3 remap |
| cmd_addr_o | output | 4 | Page address |
| done_i | input | 1 | Outstanding command finished |
| ecc_bits_i | input | 6 | Corrected-bit count, valid with a read's done |
| ecc_fail_i | input | 1 | Uncorrectable flag, valid with a read's done |
| busy_o | output | 1 | Sweep in progress |
| err_flag_o | output | 1 | Sticky uncorrectable-page flag |
| err_addr_o | output | 4 | Last uncorrectable page address |

## Verification
The assertions watch the command port on every cycle. They check that a stalled command holds still, that nothing follows a hand-off before completion, that a write-back targets the page just read, that fixed modes pick their opcode, that a command only appears while busy, and that the error flag never drops. The tick counts at which sweeps start, the band lookup, the page order, the hybrid decisions driven by the accumulating rewrite counts with their saturation, and the skipping of uncorrectable pages depend on history across whole sweeps. Only the bench's reference model and scenarios can show those.

// File: rtl/pgref_pkg.sv
package pgref_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_READ   = 2'd1,
    OP_REPROG = 2'd2,
    OP_REMAP  = 2'd3
  } op_e;

  localparam logic [1:0] MODE_REMAP  = 2'd0;
  localparam logic [1:0] MODE_REPROG = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } st_e;
endpackage

// File: rtl/pgref_ivl.sv
module pgref_ivl #(
  parameter int PE_W   = 16,
  parameter int TICK_W = 16,
  parameter int NBANDS = 3,
  parameter logic [NBANDS*PE_W-1:0]   BAND_PE  = '0,
  parameter logic [NBANDS*TICK_W-1:0] BAND_IVL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              idle_i,
  input  logic              adapt_i,
  input  logic [TICK_W-1:0] fixed_ivl_i,
  input  logic [PE_W-1:0]   pe_i,
  output logic              start_o
);
  logic [TICK_W-1:0] band_ivl;
  logic [TICK_W-1:0] eff_ivl;
  logic [TICK_W-1:0] cnt_q;
  logic [TICK_W:0]   cnt_nxt;

  // highest band whose entry threshold has been reached
  always_comb begin
    band_ivl = BAND_IVL[0 +: TICK_W];
    for (int i = 0; i < NBANDS; i++) begin
      if (pe_i >= BAND_PE[i*PE_W +: PE_W]) band_ivl = BAND_IVL[i*TICK_W +: TICK_W];
    end
  end

  always_comb begin
    eff_ivl = adapt_i ? band_ivl : fixed_ivl_i;
    if (eff_ivl == '0) eff_ivl = TICK_W'(1);
  end

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
  assign start_o = idle_i && tick_i && (cnt_nxt >= {1'b0, eff_ivl});

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (start_o)          cnt_q <= '0;
    else if (idle_i && tick_i) cnt_q <= cnt_nxt[TICK_W-1:0];
  end
endmodule

// File: rtl/pgref_policy.sv
module pgref_policy #(
  parameter int NPAGES = 16,
  parameter int AW     = 4,
  parameter int CNT_W  = 6,
  parameter int RW     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic [RW-1:0]    limit_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CNT_W-1:0] bits_i,
  input  logic             upd_i,
  input  logic             upd_remap_i,
  output logic             remap_o
);
  import pgref_pkg::*;

  logic [RW-1:0] wear [NPAGES];
  logic [RW-1:0] cur_wear;

  for (genvar g = 0; g < NPAGES; g++) begin : g_page
    logic [RW-1:0] w_q;
    logic          hit;
    assign hit = upd_i && (addr_i == AW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)          w_q <= '0;
      else if (hit) begin
        if (upd_remap_i)   w_q <= '0;
        else if (w_q != '1) w_q <= w_q + 1'b1;
      end
    end
    assign wear[g] = w_q;
  end

  assign cur_wear = wear[addr_i];

  always_comb begin
    case (mode_i)
      MODE_REMAP:  remap_o = 1'b1;
      MODE_REPROG: remap_o = 1'b0;
      default:     remap_o = (bits_i > thr_i) || (cur_wear >= limit_i);
    endcase
  end
endmodule

// File: rtl/pgref_seq.sv
module pgref_seq #(
  parameter int NPAGES = 16,
  parameter int AW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          cmd_ready_i,
  input  logic          done_i,
  input  logic          ecc_fail_i,
  input  logic          remap_sel_i,
  output logic          cmd_valid_o,
  output logic [1:0]    cmd_op_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic          busy_o,
  output logic          idle_o,
  output logic          err_flag_o,
  output logic [AW-1:0] err_addr_o,
  output logic          wb_upd_o,
  output logic          wb_remap_o
);
  import pgref_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(NPAGES - 1);

  st_e           st_q;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic          err_q;
  logic [AW-1:0] eaddr_q;
  logic          fin;

  assign fin = (st_q == ST_WAIT) && done_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_READ;
      addr_q  <= '0;
      err_q   <= 1'b0;
      eaddr_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          op_q <= OP_READ;
          st_q <= ST_ISSUE;
        end
        ST_ISSUE: if (cmd_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (done_i) begin
          if (op_q == OP_READ && !ecc_fail_i) begin
            op_q <= remap_sel_i ? OP_REMAP : OP_REPROG;
            st_q <= ST_ISSUE;
          end else begin
            if (op_q == OP_READ) begin
              err_q   <= 1'b1;
              eaddr_q <= addr_q;
            end
            op_q <= OP_READ;
            if (addr_q == LAST) begin
              addr_q <= '0;
              st_q   <= ST_IDLE;
            end else begin
              addr_q <= addr_q + 1'b1;
              st_q   <= ST_ISSUE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = (st_q == ST_ISSUE);
  assign cmd_op_o    = op_q;
  assign cmd_addr_o  = addr_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign idle_o      = (st_q == ST_IDLE);
  assign err_flag_o  = err_q;
  assign err_addr_o  = eaddr_q;
  assign wb_upd_o    = fin && (op_q != OP_READ);
  assign wb_remap_o  = (op_q == OP_REMAP);
endmodule

// File: rtl/pgref_sched.sv
module pgref_sched #(
  parameter int NPAGES = 16,
  parameter int CNT_W  = 6,
  parameter int PE_W   = 16,
  parameter int TICK_W = 16,
  parameter int RW     = 3,
  parameter int NBANDS = 3,
  parameter logic [NBANDS*PE_W-1:0]   BAND_PE  = {16'd200, 16'd100, 16'd0},
  parameter logic [NBANDS*TICK_W-1:0] BAND_IVL = {16'd4, 16'd8, 16'd12},
  localparam int AW = $clog2(NPAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              adapt_i,
  input  logic [TICK_W-1:0] fixed_ivl_i,
  input  logic [PE_W-1:0]   pe_cycles_i,
  input  logic [1:0]        mode_i,
  input  logic [CNT_W-1:0]  corr_thr_i,
  input  logic [RW-1:0]     reprog_limit_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [1:0]        cmd_op_o,
  output logic [AW-1:0]     cmd_addr_o,
  input  logic              done_i,
  input  logic [CNT_W-1:0]  ecc_bits_i,
  input  logic              ecc_fail_i,
  output logic              busy_o,
  output logic              err_flag_o,
  output logic [AW-1:0]     err_addr_o
);
  logic idle, start, remap_sel, wb_upd, wb_remap;

  pgref_ivl #(
    .PE_W(PE_W), .TICK_W(TICK_W), .NBANDS(NBANDS),
    .BAND_PE(BAND_PE), .BAND_IVL(BAND_IVL)
  ) ivl_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .idle_i(idle),
    .adapt_i(adapt_i), .fixed_ivl_i(fixed_ivl_i), .pe_i(pe_cycles_i),
    .start_o(start)
  );

  pgref_policy #(
    .NPAGES(NPAGES), .AW(AW), .CNT_W(CNT_W), .RW(RW)
  ) pol_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .thr_i(corr_thr_i),
    .limit_i(reprog_limit_i), .addr_i(cmd_addr_o), .bits_i(ecc_bits_i),
    .upd_i(wb_upd), .upd_remap_i(wb_remap), .remap_o(remap_sel)
  );

  pgref_seq #(
    .NPAGES(NPAGES), .AW(AW)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_ready_i(cmd_ready_i),
    .done_i(done_i), .ecc_fail_i(ecc_fail_i), .remap_sel_i(remap_sel),
    .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_addr_o(cmd_addr_o),
    .busy_o(busy_o), .idle_o(idle), .err_flag_o(err_flag_o),
    .err_addr_o(err_addr_o), .wb_upd_o(wb_upd), .wb_remap_o(wb_remap)
  );
endmodule

// File: rtl/pgref_sched_chk.sv
module pgref_sched_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_i,
  input logic          cmd_valid_o,
  input logic          cmd_ready_i,
  input logic [1:0]    cmd_op_o,
  input logic [AW-1:0] cmd_addr_o,
  input logic          busy_o,
  input logic          err_flag_o
);
  logic          hs;
  logic [AW-1:0] last_rd_q;

  assign hs = cmd_valid_o && cmd_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n)                        last_rd_q <= '0;
    else if (hs && cmd_op_o == 2'd1)   last_rd_q <= cmd_addr_o;
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_addr_o))); // R6
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> !cmd_valid_o); // R5
  AST_WB_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && cmd_op_o != 2'd1) |-> (cmd_addr_o == last_rd_q)); // R4
  AST_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> (busy_o && cmd_op_o != 2'd0)); // R4
  AST_REMAP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && cmd_op_o != 2'd1 && mode_i == 2'd0) |-> (cmd_op_o == 2'd3)); // R7
  AST_REPROG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && cmd_op_o != 2'd1 && mode_i == 2'd1) |-> (cmd_op_o == 2'd2)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag_o |=> err_flag_o); // R11
endmodule

bind pgref_sched pgref_sched_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cmd_valid_o(cmd_valid_o),
  .cmd_ready_i(cmd_ready_i), .cmd_op_o(cmd_op_o), .cmd_addr_o(cmd_addr_o),
  .busy_o(busy_o), .err_flag_o(err_flag_o)
);

// File: tb/pgref_sched_tb.sv
module pgref_sched_tb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        adapt_i = 1'b0;
  logic [15:0] fixed_ivl_i = 16'd5;
  logic [15:0] pe_cycles_i = 16'd0;
  logic [1:0]  mode_i = 2'd0;
  logic [5:0]  corr_thr_i = 6'd3;
  logic [2:0]  reprog_limit_i = 3'd2;
  logic        cmd_valid_o;
  logic        cmd_ready_i = 1'b1;
  logic [1:0]  cmd_op_o;
  logic [3:0]  cmd_addr_o;
  logic        done_i = 1'b0;
  logic [5:0]  ecc_bits_i = '0;
  logic        ecc_fail_i = 1'b0;
  logic        busy_o;
  logic        err_flag_o;
  logic [3:0]  err_addr_o;

  always #10 clk = ~clk;

  pgref_sched dut_i (.*);

  int total = 0;
  int bad = 0;
  int bits_m [N];
  bit fail_m [N];
  int wear_m [N];
  int expq [$];
  bit mdl_err = 0;
  int mdl_eaddr = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference: expected command codes (op*256 + addr) for one sweep
  task automatic build_sweep();
    expq.delete();
    for (int p = 0; p < N; p++) begin
      bit rm;
      expq.push_back(256 + p);
      if (fail_m[p]) continue;
      if (mode_i == 2'd0)      rm = 1;
      else if (mode_i == 2'd1) rm = 0;
      else rm = (bits_m[p] > int'(corr_thr_i)) || (wear_m[p] >= int'(reprog_limit_i));
      expq.push_back((rm ? 3 : 2) * 256 + p);
      if (rm) wear_m[p] = 0;
      else if (wear_m[p] < 7) wear_m[p]++;
    end
  endtask

  task automatic run_sweep(input int exp_ticks, input bit bp, input string req);
    int n = 0;
    int pending = 0;
    int paddr = 0;
    int cyc = 0;
    bit err_next = 0;
    build_sweep();
    for (int g = 0; g < 5000; g++) begin
      @(negedge clk);
      if (cmd_valid_o) begin tick_i = 1'b0; break; end
      tick_i = 1'b1;
      n++;
    end
    if (exp_ticks > 0) chk(n == exp_ticks, req, n, exp_ticks);
    for (int g = 0; g < 20000; g++) begin
      if (g > 0) @(negedge clk);
      done_i = 1'b0;
      if (err_next) begin mdl_err = 1; mdl_eaddr = paddr; err_next = 0; end
      chk(err_flag_o == mdl_err && (!mdl_err || err_addr_o == 4'(mdl_eaddr)),
          "R11", int'(err_addr_o) + 100 * int'(err_flag_o), mdl_eaddr + 100 * int'(mdl_err));
      cyc++;
      cmd_ready_i = bp ? (cyc % 3 == 0) : 1'b1;
      if (pending > 0) begin
        if (cmd_valid_o) chk(0, "R5", 1, 0);
        pending--;
        if (pending == 0) begin
          done_i = 1'b1;
          ecc_bits_i = 6'(bits_m[paddr]);
          ecc_fail_i = fail_m[paddr];
          if (fail_m[paddr] && cmd_op_o == 2'd1) err_next = 1;
        end
      end else if (cmd_valid_o && cmd_ready_i) begin
        int act = int'(cmd_op_o) * 256 + int'(cmd_addr_o);
        int exp = (expq.size() > 0) ? expq[0] : -1;
        // R4 order, R7/R8/R9/R10 op choice
        chk(act == exp, req, act, exp);
        if (expq.size() > 0) void'(expq.pop_front());
        pending = 2;
        paddr = int'(cmd_addr_o);
      end else if (!busy_o && expq.size() == 0 && !err_next) begin
        break;
      end
    end
    cmd_ready_i = 1'b1;
    chk(expq.size() == 0 && !busy_o, "R4", expq.size(), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < N; p++) begin bits_m[p] = 0; fail_m[p] = 0; wear_m[p] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!cmd_valid_o, "R1", cmd_valid_o, 0);
    chk(!busy_o, "R1", busy_o, 0);
    chk(!err_flag_o && err_addr_o == 0, "R1", err_flag_o, 0);
    // R5 stray done while idle is ignored
    done_i = 1'b1; ecc_fail_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0; ecc_fail_i = 1'b0;
    @(negedge clk);
    chk(!busy_o && !cmd_valid_o && !err_flag_o, "R5", busy_o + err_flag_o, 0);

    // R2 fixed period, R7 remap-only
    mode_i = 2'd0; fixed_ivl_i = 16'd5;
    run_sweep(5, 0, "R7");
    fixed_ivl_i = 16'd0;
    run_sweep(1, 0, "R2");
    // R8 reprogram-only with back-pressure (R6)
    mode_i = 2'd1; fixed_ivl_i = 16'd3;
    run_sweep(3, 1, "R8");
    // R9 hybrid: bits p%5, threshold 3, limit 2
    for (int p = 0; p < N; p++) bits_m[p] = p % 5;
    mode_i = 2'd2; fixed_ivl_i = 16'd1;
    run_sweep(1, 0, "R9");
    mode_i = 2'd3;
    run_sweep(1, 1, "R9");
    // R10 saturation: many reprogram sweeps then limit 7
    mode_i = 2'd1;
    for (int k = 0; k < 9; k++) run_sweep(1, 0, "R10");
    mode_i = 2'd2; reprog_limit_i = 3'd7; corr_thr_i = 6'd63;
    run_sweep(1, 0, "R10");
    // R11 uncorrectable pages 5 and 9
    fail_m[5] = 1; fail_m[9] = 1; corr_thr_i = 6'd3; reprog_limit_i = 3'd2;
    run_sweep(1, 0, "R11");
    chk(err_flag_o && err_addr_o == 4'd9, "R11", err_addr_o, 9);
    fail_m[5] = 0; fail_m[9] = 0;
    // R3 adaptive bands
    mode_i = 2'd0; adapt_i = 1'b1;
    pe_cycles_i = 16'd50;    run_sweep(12, 0, "R3");
    pe_cycles_i = 16'd150;   run_sweep(8, 0, "R3");
    pe_cycles_i = 16'd200;   run_sweep(4, 0, "R3");
    pe_cycles_i = 16'd60000; run_sweep(4, 0, "R3");
    chk(err_flag_o, "R11", err_flag_o, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule